// File: doc/BRIEF.md
# Operand-Timed Sequential Multiplier

This block multiplies two 16-bit operands into a 32-bit product, either as unsigned numbers or as two's-complement numbers. It is meant for a processor core that must reproduce, cycle for cycle, how long a register-to-register multiply takes. The completion time is not fixed. It is computed from the bit pattern of the source operand when the operation is accepted, and the done pulse is held back until exactly that many clocks have passed.

The latency is 38 + 2n clocks. In unsigned mode, n is the number of set bits in the source. In signed mode, a zero is appended below the source's least significant bit to form a 17-bit value, and n is the number of neighbouring bit pairs in that value that differ. Either way the latency lies between 38 and 70 clocks. A 0x5555 source is the slowest case in signed mode. A 0xFFFF source is the slowest case in unsigned mode.

The product itself is formed by a radix-2 shift-add engine that needs one clock per operand bit, so it is always finished well before the timer expires. The product and the N and Z flags are updated only in the cycle in which done pulses.

Top module: `mul_latency_unit`

## Requirements
- R1: With `sgn_sel`=0, the product is the unsigned product `src_op * dst_op`, 32 bits wide.
- R2: With `sgn_sel`=1, the product is the 32-bit two's-complement product of the two sign-extended operands.
- R3: With `sgn_sel`=0, done goes high exactly 38 + 2·popcount(`src_op`) clock edges after the edge that samples `start`. That sampling edge counts as edge 1.
- R4: With `sgn_sel`=1, the latency is 38 + 2n. Here n counts the positions i = 0..15 where bit i of `src_op` differs from bit i-1, taking bit -1 as 0.
- R5: The latency stays within 38..70. Source 0x0000 gives 38 in both modes. Source 0xFFFF gives 70 unsigned and 40 signed. Source 0x5555 gives 70 signed.
- R6: `done` is high for exactly one cycle per accepted operation. `busy` is high from the cycle after acceptance until the cycle before done, and is low while done is high.
- R7: A `start` sampled while `busy` is high is ignored. It produces no extra done pulse and does not alter the running operation's product or latency.
- R8: `flag_n` equals product bit 31 and `flag_z` is 1 when all 32 product bits are 0. `product`, `flag_n` and `flag_z` change only in a done cycle and hold their values otherwise.
- R9: While reset is high, and right after it, `busy`, `done`, `product`, `flag_n` and `flag_z` are all 0.
- R10: A `start` sampled at the edge that ends a done cycle is accepted, so operations can run back to back without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiply; sampled when `busy` is low |
| sgn_sel | input | 1 | 1 = signed operands, 0 = unsigned |
| src_op | input | 16 | Source operand; its bit pattern sets the latency |
| dst_op | input | 16 | Destination operand |
| busy | output | 1 | An accepted operation is still in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 32 | Result of the last completed operation |
| flag_n | output | 1 | Product bit 31 of the last completed operation |
| flag_z | output | 1 | Last completed product was zero |

## Verification
Two events can fall in the same cycle: the completion of one operation and the acceptance of the next. The bench provokes this by waiting for done to be seen and raising `start` in that same cycle.

The scoreboard then confirms two things. The retiring operation keeps its own product, flags and latency. The new operation's latency is counted from that very edge, with no lost cycle.

A second case puts a `start` on a cycle where `busy` is high, partway through an operation. The bench judges it by `busy` staying high, by the absence of any unexpected done, and by the first operation's product and latency matching unchanged.

// File: rtl/mlu_pkg.sv
package mlu_pkg;
   timeunit 1ns; timeprecision 1ps;

   // operand interpretation selected by the sgn_sel pin
   typedef enum logic {
      MODE_UNSIGNED = 1'b0,
      MODE_SIGNED   = 1'b1
   } mlu_mode_e;

   // longest possible latency for an operand width
   function automatic int lat_ceiling(input int op_w, input int base_cyc, input int step_cyc);
      return base_cyc + step_cyc * op_w;
   endfunction

   // counter width able to hold the longest latency
   function automatic int lat_bits(input int op_w, input int base_cyc, input int step_cyc);
      return $clog2(lat_ceiling(op_w, base_cyc, step_cyc) + 1);
   endfunction
endpackage

// File: rtl/mlu_cost.sv
module mlu_cost #(
   parameter int OP_W     = 16,
   parameter int BASE_CYC = 38,
   parameter int STEP_CYC = 2,
   parameter int LAT_W    = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OP_W-1:0]  src,
   input  logic             sgn,
   output logic [LAT_W-1:0] lat
);
   timeunit 1ns; timeprecision 1ps;

   localparam int CNT_W   = $clog2(OP_W + 1);
   localparam int LAT_MAX = BASE_CYC + STEP_CYC * OP_W;

   logic [OP_W-1:0]  hit_u;   // set bits of the source
   logic [OP_W-1:0]  hit_s;   // edges in {src, 1'b0}
   logic [OP_W-1:0]  hit;
   logic [CNT_W-1:0] n_cnt;

   genvar gi;
   generate
      for (gi = 0; gi < OP_W; gi++) begin : g_bit
         assign hit_u[gi] = src[gi];
         if (gi == 0) begin : g_lsb
            assign hit_s[gi] = src[0];
         end else begin : g_mid
            assign hit_s[gi] = src[gi] ^ src[gi-1];
         end
      end
   endgenerate

   assign hit = sgn ? hit_s : hit_u;

   always_comb begin
      n_cnt = '0;
      for (int i = 0; i < OP_W; i++) begin
         n_cnt = n_cnt + CNT_W'(hit[i]);
      end
   end

   assign lat = LAT_W'(BASE_CYC) + LAT_W'(STEP_CYC) * LAT_W'(n_cnt);

   // R5: computed latency stays in its legal window
   p_lat_window_r5: assert property (@(posedge clk) disable iff (rst)
      (lat >= LAT_W'(BASE_CYC)) && (lat <= LAT_W'(LAT_MAX)));
endmodule

// File: rtl/mlu_timer.sv
module mlu_timer #(
   parameter int LAT_W = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [LAT_W-1:0] lat,
   output logic             active,
   output logic             last
);
   timeunit 1ns; timeprecision 1ps;

   logic [LAT_W-1:0] cnt;

   assign last = active && (cnt == LAT_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (load && !active) begin
         active <= 1'b1;
         cnt    <= lat - LAT_W'(1);
      end else if (active) begin
         if (cnt == LAT_W'(1)) begin
            active <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt - LAT_W'(1);
         end
      end
   end

   // R3: an accepted request arms the timer with latency minus one
   p_arm_r3: assert property (@(posedge clk) disable iff (rst)
      (load && !active) |=> (active && cnt == $past(lat) - LAT_W'(1)));
   // R7: a running count only steps down, whatever load does
   p_no_rearm_r7: assert property (@(posedge clk) disable iff (rst)
      (active && !last) |=> (active && cnt == $past(cnt) - LAT_W'(1)));
endmodule

// File: rtl/mlu_mul.sv
module mlu_mul #(
   parameter int OP_W      = 16,
   parameter bit ITERATIVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              sgn,
   input  logic [OP_W-1:0]   src,
   input  logic [OP_W-1:0]   dst,
   output logic [2*OP_W-1:0] prod,
   output logic              ready
);
   timeunit 1ns; timeprecision 1ps;

   localparam int PW    = 2 * OP_W;
   localparam int IDX_W = (OP_W > 2) ? $clog2(OP_W) : 1;

   logic [PW-1:0] ext_dst;
   logic [PW-1:0] ext_src;
   assign ext_dst = {{OP_W{sgn & dst[OP_W-1]}}, dst};
   assign ext_src = {{OP_W{sgn & src[OP_W-1]}}, src};

   generate
      if (ITERATIVE) begin : g_shift_add
         logic [PW-1:0]    acc;
         logic [PW-1:0]    mcand;
         logic [PW-1:0]    addend;
         logic [OP_W-1:0]  mplier;
         logic [IDX_W-1:0] idx;
         logic             run;
         logic             sgn_q;
         logic             last_step;

         assign addend    = mplier[0] ? mcand : '0;
         assign last_step = (idx == IDX_W'(OP_W - 1));

         always_ff @(posedge clk) begin
            if (rst) begin
               acc    <= '0;
               mcand  <= '0;
               mplier <= '0;
               idx    <= '0;
               run    <= 1'b0;
               sgn_q  <= 1'b0;
            end else if (load) begin
               acc    <= '0;
               mcand  <= ext_dst;
               mplier <= src;
               idx    <= '0;
               run    <= 1'b1;
               sgn_q  <= sgn;
            end else if (run) begin
               // top source bit carries negative weight in signed mode
               acc    <= (last_step && sgn_q) ? acc - addend : acc + addend;
               mcand  <= mcand << 1;
               mplier <= mplier >> 1;
               idx    <= idx + IDX_W'(1);
               if (last_step) run <= 1'b0;
            end
         end

         assign prod  = acc;
         assign ready = !run;

         // R1: once finished, the accumulator holds until the next load
         p_acc_hold_r1: assert property (@(posedge clk) disable iff (rst)
            (!run && !load) |=> $stable(acc));
      end else begin : g_flat
         logic [PW-1:0] prod_q;

         always_ff @(posedge clk) begin
            if (rst)       prod_q <= '0;
            else if (load) prod_q <= ext_src * ext_dst;
         end

         assign prod  = prod_q;
         assign ready = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/mul_latency_unit.sv
module mul_latency_unit #(
   parameter int OP_W      = 16,
   parameter int BASE_CYC  = 38,
   parameter int STEP_CYC  = 2,
   parameter bit ITERATIVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              sgn_sel,
   input  logic [OP_W-1:0]   src_op,
   input  logic [OP_W-1:0]   dst_op,
   output logic              busy,
   output logic              done,
   output logic [2*OP_W-1:0] product,
   output logic              flag_n,
   output logic              flag_z
);
   timeunit 1ns; timeprecision 1ps;
   import mlu_pkg::*;

   localparam int PW    = 2 * OP_W;
   localparam int LAT_W = lat_bits(OP_W, BASE_CYC, STEP_CYC);

   generate
      if (OP_W < 2) begin : g_bad_width
         $error("mul_latency_unit: OP_W must be at least 2");
      end
      if (BASE_CYC < 2 || STEP_CYC < 0) begin : g_bad_cost
         $error("mul_latency_unit: BASE_CYC >= 2 and STEP_CYC >= 0 required");
      end
      if (ITERATIVE && BASE_CYC <= OP_W) begin : g_bad_iter
         $error("mul_latency_unit: shift-add engine needs BASE_CYC > OP_W");
      end
   endgenerate

   mlu_mode_e        mode;
   logic             accept;
   logic [LAT_W-1:0] lat;
   logic             t_active;
   logic             t_last;
   logic [PW-1:0]    m_prod;
   logic             m_ready;

   assign mode   = mlu_mode_e'(sgn_sel);
   assign accept = start && !busy;
   assign busy   = t_active;

   mlu_cost #(
      .OP_W(OP_W), .BASE_CYC(BASE_CYC), .STEP_CYC(STEP_CYC), .LAT_W(LAT_W)
   ) u_cost (
      .clk(clk), .rst(rst), .src(src_op),
      .sgn(mode == MODE_SIGNED), .lat(lat)
   );

   mlu_timer #(.LAT_W(LAT_W)) u_timer (
      .clk(clk), .rst(rst), .load(accept), .lat(lat),
      .active(t_active), .last(t_last)
   );

   mlu_mul #(.OP_W(OP_W), .ITERATIVE(ITERATIVE)) u_mul (
      .clk(clk), .rst(rst), .load(accept), .sgn(mode == MODE_SIGNED),
      .src(src_op), .dst(dst_op), .prod(m_prod), .ready(m_ready)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         done    <= 1'b0;
         product <= '0;
         flag_n  <= 1'b0;
         flag_z  <= 1'b0;
      end else begin
         done <= t_last;
         if (t_last) begin
            product <= m_prod;
            flag_n  <= m_prod[PW-1];
            flag_z  <= (m_prod == '0);
         end
      end
   end

   // R1: the engine has finished by the time the timer expires
   p_engine_ready_r1: assert property (@(posedge clk) disable iff (rst)
      t_last |-> m_ready);
   // R6: done lasts one cycle and never overlaps busy
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
   // R8: results move only with done, and Z agrees with the product
   p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !done |-> ($stable(product) && $stable(flag_n) && $stable(flag_z)));
   p_zero_flag_r8: assert property (@(posedge clk) disable iff (rst)
      done |-> (flag_z == (product == '0)));
   // R10: a start in a done cycle is taken at once
   p_back_to_back_r10: assert property (@(posedge clk) disable iff (rst)
      (done && start) |=> busy);
endmodule

// File: tb/sim_mul_latency_unit.sv
module sim_mul_latency_unit;
   timeunit 1ns; timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        sgn_sel = 1'b0;
   logic [15:0] src_op = '0;
   logic [15:0] dst_op = '0;
   logic        busy, done, flag_n, flag_z;
   logic [31:0] product;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit ended = 0;

   typedef struct {
      logic [31:0] prod;
      int          lat;
      int          start_edge;
      string       tag_p;
      string       tag_l;
   } exp_t;
   exp_t sb[$];

   mul_latency_unit u0 (
      .clk(clk), .rst(rst), .start(start), .sgn_sel(sgn_sel),
      .src_op(src_op), .dst_op(dst_op), .busy(busy), .done(done),
      .product(product), .flag_n(flag_n), .flag_z(flag_z)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   function automatic int ones16(input logic [15:0] v);
      int c = 0;
      for (int i = 0; i < 16; i++) c += int'(v[i]);
      return c;
   endfunction

   function automatic int edges16(input logic [15:0] v);
      logic [16:0] w = {v, 1'b0};
      int c = 0;
      for (int i = 0; i < 16; i++) c += int'(w[i+1] ^ w[i]);
      return c;
   endfunction

   // driver: launch one operation and push its expectation
   task automatic run_op(input logic sg, input logic [15:0] s, input logic [15:0] d,
                         input bit b2b, input string ltag);
      exp_t   e;
      longint a, b;
      if (b2b) begin
         @(negedge clk);
         while (!done) @(negedge clk);
      end else begin
         @(negedge clk);
         while (busy || done) @(negedge clk);
      end
      a = sg ? longint'($signed(s)) : longint'(s);
      b = sg ? longint'($signed(d)) : longint'(d);
      e.prod  = 32'(a * b);
      e.lat   = 38 + 2 * (sg ? edges16(s) : ones16(s));
      e.tag_p = sg ? "R2" : "R1";
      e.tag_l = (ltag != "") ? ltag : (sg ? "R4" : "R3");
      sgn_sel = sg; src_op = s; dst_op = d; start = 1'b1;
      e.start_edge = cyc + 1;
      sb.push_back(e);
      @(negedge clk);
      start = 1'b0;
   endtask

   // monitor: compare each done against the oldest expectation
   logic [31:0] held_p = '0;
   logic        held_n = 1'b0;
   logic        held_z = 1'b0;
   bit          prev_done = 0;
   always @(negedge clk) begin
      if (!rst) begin
         if (done) begin
            chk(!busy, "R6", "busy during done", 32'(busy), 32'd0);
            chk(!prev_done, "R6", "done longer than one cycle", 32'(prev_done), 32'd0);
            if (sb.size() == 0) begin
               chk(1'b0, "R7", "done with nothing outstanding", 32'd1, 32'd0);
            end else begin
               exp_t e;
               int   meas;
               e = sb.pop_front();
               meas = cyc - e.start_edge + 1;
               chk(product == e.prod, e.tag_p, "product", product, e.prod);
               chk(meas == e.lat, e.tag_l, "latency", 32'(meas), 32'(e.lat));
               chk(flag_n == e.prod[31], "R8", "N flag", 32'(flag_n), 32'(e.prod[31]));
               chk(flag_z == (e.prod == 0), "R8", "Z flag", 32'(flag_z), 32'(e.prod == 0));
            end
            held_p = product; held_n = flag_n; held_z = flag_z;
         end else begin
            chk(product == held_p && flag_n == held_n && flag_z == held_z,
                "R8", "result moved outside done", product, held_p);
         end
         prev_done = done;
      end
   end

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(!busy && !done, "R9", "busy/done in reset", {30'd0, busy, done}, 32'd0);
      chk(product == 0 && !flag_n && !flag_z, "R9", "result in reset", product, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      chk(!busy && !done && product == 0 && !flag_n && !flag_z, "R9",
          "state after reset", product, 32'd0);

      // boundary sources
      run_op(1'b0, 16'h0000, 16'h1234, 0, "R5");
      run_op(1'b1, 16'h0000, 16'h8000, 0, "R5");
      run_op(1'b0, 16'hFFFF, 16'hFFFF, 0, "R5");
      run_op(1'b1, 16'hFFFF, 16'h7FFF, 0, "R4");
      run_op(1'b1, 16'h5555, 16'hABCD, 0, "R5");
      run_op(1'b0, 16'h5555, 16'h0003, 0, "R3");
      run_op(1'b1, 16'h8000, 16'h8000, 0, "R2");
      run_op(1'b1, 16'h0001, 16'hFFFF, 0, "R2");

      // R7: start while busy must be ignored
      run_op(1'b0, 16'h00F0, 16'h0101, 0, "R7");
      repeat (5) @(negedge clk);
      sgn_sel = 1'b1; src_op = 16'h5555; dst_op = 16'hFFFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R7", "busy after ignored start", 32'(busy), 32'd1);

      // R10: starts landing in the done cycle
      run_op(1'b1, 16'h1357, 16'h2468, 0, "R4");
      run_op(1'b0, 16'hA5A5, 16'h5A5A, 1, "R10");
      run_op(1'b1, 16'hF00F, 16'h0F0F, 1, "R10");
      run_op(1'b0, 16'h0001, 16'h0000, 1, "R10");

      // random mix, some back to back
      for (int k = 0; k < 60; k++) begin
         logic        sg;
         logic [15:0] s, d;
         bit          bb;
         sg = 1'($urandom);
         s  = 16'($urandom);
         d  = 16'($urandom);
         bb = (($urandom % 3) == 0);
         run_op(sg, s, d, bb, "");
      end

      @(negedge clk);
      while (busy || done) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R6", "operations without done", 32'(sb.size()), 32'd0);
      finish_run();
   end
endmodule